// File: doc/BRIEF.md
# Grouped Pin Interrupt Combiner

This block turns a set of general-purpose input pins, spread over up to eight ports of up to 32 pins each, into a single interrupt line. Software picks which pins take part through per-port enable words. It gives each pin a polarity through per-port polarity words. A control word chooses whether the enabled pins are combined as "any active" or "all active", and whether the interrupt latches on a rising edge of that combined condition or follows it as a level.

Configuration goes through a simple synchronous register port. A write strobe, a byte address and a 32-bit write word update the registers on the clock edge. The read word is a combinational decode of the current address. The pin inputs are assumed to be already synchronised to the block clock. The interrupt output is registered.

Register layout, as byte addresses: the control word is at 0x00. The polarity word of port p is at 0x20 + 4·p, and the enable word of port p is at 0x40 + 4·p. In those words, bit i corresponds to pin i of the port, and pin i of port p sits at position p·PORT_W + i of the flat pin input. Control word: bit 0 is the status (write 1 to clear), bit 1 is the combine mode (0 = any, 1 = all), and bit 2 is the trigger mode (0 = rising edge, 1 = level). Bits 3 to 31 read as zero.

Top module: `gpint_group`

## Requirements
- R1: After reset every polarity word, every enable word and the control word read as zero, and irq is 0.
- R2: Polarity and enable words read back what was written, limited to PORT_W bits. The control word reads back bits 1 and 2 as written, with bits 3..31 always zero. Addresses of ports at or beyond NUM_PORTS, and all other unmapped addresses, read zero, and writes to them change nothing.
- R3: A pin counts as active when its level equals its polarity bit: polarity 1 means active high, polarity 0 means active low.
- R4: With control bit 1 = 0, the condition is true when at least one enabled pin is active.
- R5: With control bit 1 = 1, the condition is true when every enabled pin, across all ports, is active.
- R6: With all enable bits zero, the condition is false in both combine modes, for every pin level and polarity.
- R7: With control bit 2 = 0 (edge), the status sets on the clock edge where the condition is true and was false at the previous edge. It stays set after the condition falls, and a condition that stays true does not set it again after a clear.
- R8: In edge mode, a control write with bit 0 = 1 clears the status at that edge, and a write with bit 0 = 0 does not. If a rising edge of the condition lands on the same clock edge as the clear, the status stays set.
- R9: With control bit 2 = 1 (level), the status equals the condition sampled at the previous clock edge, and writes of 1 to bit 0 have no effect.
- R10: irq equals the status, and control bit 0 reads the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on the clock edge |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | NUM_PORTS*PORT_W | Synchronised pin levels, port p at bits p*PORT_W upward |
| irq | output | 1 | Group interrupt (registered status) |

## Verification
The assertions assume that pin_in and the register inputs are already synchronous to clk and hold stable, known values around each rising edge. The bench meets this by driving every input only at the falling edge, and by keeping all values defined from reset onward. Edge-mode properties also take for granted that the trigger mode is not changed while a clear is in flight. The bench therefore changes the control word only through single writes, each followed by a settle cycle. Combination is swept over every pin pattern of a reduced two-port, four-pin instance, under several polarity and enable mixes, with the expected value worked out arithmetically from the polarity and enable words.

// File: rtl/gpint_pkg.sv
package gpint_pkg;
  // Control word bit positions (decoded by software).
  localparam int CTRL_STATUS_BIT  = 0;
  localparam int CTRL_COMBINE_BIT = 1;
  localparam int CTRL_TRIG_BIT    = 2;

  // Byte offsets of the register groups.
  localparam int CTRL_OFS    = 'h00;
  localparam int POL_BASE    = 'h20;
  localparam int ENA_BASE    = 'h40;
  localparam int PORT_STRIDE = 4;

  typedef enum logic {
    COMB_ANY = 1'b0,
    COMB_ALL = 1'b1
  } comb_mode_e;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  typedef struct packed {
    trig_mode_e trig;
    comb_mode_e comb;
  } ctrl_cfg_t;
endpackage

// File: rtl/gpint_regs.sv
module gpint_regs
  import gpint_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        status,
  output ctrl_cfg_t                   cfg,
  output logic [NUM_PORTS*PORT_W-1:0] pol_flat,
  output logic [NUM_PORTS*PORT_W-1:0] ena_flat,
  output logic                        clr_req,
  output logic [DATA_W-1:0]           rdata
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

  function automatic logic [ADDR_W-1:0] slot_addr(input int base, input int port);
    return ADDR_W'(base + PORT_STRIDE * port);
  endfunction

  logic [PORT_W-1:0] pol_q [NUM_PORTS];
  logic [PORT_W-1:0] ena_q [NUM_PORTS];
  logic              ctrl_hit;

  assign ctrl_hit = wr_en && (addr == CTRL_A);
  assign clr_req  = ctrl_hit && wdata[CTRL_STATUS_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{trig: TRIG_EDGE, comb: COMB_ANY};
    end else if (ctrl_hit) begin
      cfg <= '{trig: trig_mode_e'(wdata[CTRL_TRIG_BIT]),
               comb: comb_mode_e'(wdata[CTRL_COMBINE_BIT])};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        pol_q[p] <= '0;
        ena_q[p] <= '0;
      end
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (addr == slot_addr(POL_BASE, p)) pol_q[p] <= wdata[PORT_W-1:0];
        if (addr == slot_addr(ENA_BASE, p)) ena_q[p] <= wdata[PORT_W-1:0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_flat
    assign pol_flat[p*PORT_W +: PORT_W] = pol_q[p];
    assign ena_flat[p*PORT_W +: PORT_W] = ena_q[p];
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_A) begin
      rdata[CTRL_STATUS_BIT]  = status;
      rdata[CTRL_COMBINE_BIT] = cfg.comb;
      rdata[CTRL_TRIG_BIT]    = cfg.trig;
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == slot_addr(POL_BASE, p)) rdata = DATA_W'(pol_q[p]);
      if (addr == slot_addr(ENA_BASE, p)) rdata = DATA_W'(ena_q[p]);
    end
  end

  // R2: reserved control bits never read as one.
  a_r2_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == CTRL_A) |-> (rdata[DATA_W-1:CTRL_TRIG_BIT+1] == '0));
endmodule

// File: rtl/gpint_match.sv
module gpint_match
  import gpint_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 32
) (
  input  logic [NUM_PORTS*PORT_W-1:0] pins,
  input  logic [NUM_PORTS*PORT_W-1:0] pol,
  input  logic [NUM_PORTS*PORT_W-1:0] ena,
  input  comb_mode_e                  comb,
  output logic                        cond
);
  logic [NUM_PORTS-1:0] hit;   // some enabled pin of the port is active
  logic [NUM_PORTS-1:0] miss;  // some enabled pin of the port is inactive
  logic [NUM_PORTS-1:0] used;  // port has any enabled pin

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] differs;
    logic [PORT_W-1:0] en_w;
    assign en_w    = ena[p*PORT_W +: PORT_W];
    assign differs = pins[p*PORT_W +: PORT_W] ^ pol[p*PORT_W +: PORT_W];
    assign hit[p]  = |(en_w & ~differs);
    assign miss[p] = |(en_w & differs);
    assign used[p] = |en_w;
  end

  assign cond = (comb == COMB_ALL) ? ((|used) && !(|miss)) : (|hit);
endmodule

// File: rtl/gpint_trigger.sv
module gpint_trigger
  import gpint_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cond,
  input  trig_mode_e trig,
  input  logic       clr,
  output logic       status
);
  logic cond_q;
  logic rise;

  assign rise = cond && !cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      status <= 1'b0;
    end else begin
      cond_q <= cond;
      if (trig == TRIG_LEVEL) status <= cond;
      else                    status <= rise || (status && !clr);
    end
  end

  a_r7_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_EDGE && cond && !cond_q) |=> status);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_EDGE && status && !clr) |=> status);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_EDGE && clr && !(cond && !cond_q)) |=> !status);

  a_r9_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_LEVEL) |=> (status == $past(cond)));
endmodule

// File: rtl/gpint_group.sv
module gpint_group
  import gpint_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic                        irq
);
  localparam int DATA_W = 32;
  localparam int PINS   = NUM_PORTS * PORT_W;

  ctrl_cfg_t         cfg;
  logic [PINS-1:0]   pol_flat;
  logic [PINS-1:0]   ena_flat;
  logic              clr_req;
  logic              cond;
  logic              status;

  gpint_regs #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .cfg(cfg), .pol_flat(pol_flat), .ena_flat(ena_flat),
    .clr_req(clr_req), .rdata(reg_rdata)
  );

  gpint_match #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_match (
    .pins(pin_in), .pol(pol_flat), .ena(ena_flat), .comb(cfg.comb), .cond(cond)
  );

  gpint_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .cond(cond), .trig(cfg.trig), .clr(clr_req), .status(status)
  );

  assign irq = status;

  // R6: no enabled pin never yields a true condition.
  a_r6_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_flat == '0) |-> !cond);

  // R5: in all-mode a true condition needs every enabled pin to match its polarity.
  a_r5_all_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.comb == COMB_ALL && cond) |-> ((ena_flat & (pin_in ^ pol_flat)) == '0));

  // R4: in any-mode a true condition needs at least one matching enabled pin.
  a_r4_any_match: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.comb == COMB_ANY && cond) |-> ((ena_flat & ~(pin_in ^ pol_flat)) != '0));
endmodule

// File: tb/sim_gpint_group.sv
module sim_gpint_group;
  localparam int NP = 2;
  localparam int PW = 4;
  localparam int AW = 8;
  localparam int NPIN = NP * PW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NPIN-1:0] pin_in = '0;
  logic            irq;

  int n_chk = 0;
  int n_err = 0;

  gpint_group #(.NUM_PORTS(NP), .PORT_W(PW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .irq(irq)
  );

  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic set_cfg(input logic [NPIN-1:0] pol, input logic [NPIN-1:0] ena);
    wr('h20, 32'(pol[3:0])); wr('h24, 32'(pol[7:4]));
    wr('h40, 32'(ena[3:0])); wr('h44, 32'(ena[7:4]));
  endtask

  function automatic logic model(input logic [NPIN-1:0] pins, input logic [NPIN-1:0] pol,
                                 input logic [NPIN-1:0] ena, input logic all_mode);
    logic [NPIN-1:0] act;
    act = ena & ~(pins ^ pol);
    if (all_mode) return (ena != 0) && (act == ena);
    return act != 0;
  endfunction

  task automatic sweep(input string req, input logic [NPIN-1:0] pol,
                       input logic [NPIN-1:0] ena, input logic all_mode);
    wr('h00, {29'd0, 1'b1, all_mode, 1'b0});  // level mode
    set_cfg(pol, ena);
    for (int v = 0; v < (1 << NPIN); v++) begin
      pin_in = NPIN'(v);
      @(negedge clk);
      chk(req, 32'(irq), 32'(model(NPIN'(v), pol, ena, all_mode)));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    rd('h00, d); chk("R1 ctrl", d, 32'd0);
    rd('h20, d); chk("R1 pol0", d, 32'd0);
    rd('h44, d); chk("R1 ena1", d, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);

    // R2: register readback and decode
    wr('h00, 32'hFFFF_FFFE); rd('h00, d); chk("R2 ctrl reserved", d, 32'h6);
    wr('h00, 32'h0);         rd('h00, d); chk("R2 ctrl zero", d, 32'h0);
    wr('h20, 32'hFFFF_FFFF); rd('h20, d); chk("R2 pol0 width", d, 32'hF);
    wr('h44, 32'hA);         rd('h44, d); chk("R2 ena1", d, 32'hA);
    wr('h28, 32'hF);         rd('h28, d); chk("R2 absent port", d, 32'h0);
    wr('h10, 32'hF);         rd('h10, d); chk("R2 unmapped", d, 32'h0);
    rd('h20, d); chk("R2 pol0 untouched", d, 32'hF);
    rd('h44, d); chk("R2 ena1 untouched", d, 32'hA);
    rd('h24, d); chk("R2 pol1 untouched", d, 32'h0);
    set_cfg('0, '0);

    // R3: polarity on a single pin, level mode, any-combine
    wr('h00, 32'h4);
    set_cfg(8'h00, 8'h01);
    pin_in = 8'h00; @(negedge clk); chk("R3 low-active pin low", 32'(irq), 32'd1);
    pin_in = 8'h01; @(negedge clk); chk("R3 low-active pin high", 32'(irq), 32'd0);
    set_cfg(8'h01, 8'h01);
    pin_in = 8'h01; @(negedge clk); chk("R3 high-active pin high", 32'(irq), 32'd1);
    pin_in = 8'h00; @(negedge clk); chk("R3 high-active pin low", 32'(irq), 32'd0);

    // R4 / R5: full sweeps, R9 level latency implied
    sweep("R4 any FF/FF", 8'hFF, 8'hFF, 1'b0);
    sweep("R5 all FF/FF", 8'hFF, 8'hFF, 1'b1);
    sweep("R4 any 00/FF", 8'h00, 8'hFF, 1'b0);
    sweep("R5 all 00/FF", 8'h00, 8'hFF, 1'b1);
    sweep("R4 any A5/3C", 8'hA5, 8'h3C, 1'b0);
    sweep("R5 all A5/3C", 8'hA5, 8'h3C, 1'b1);
    sweep("R4 any 0F/81", 8'h0F, 8'h81, 1'b0);
    sweep("R5 all 0F/81", 8'h0F, 8'h81, 1'b1);
    sweep("R5 all F0/10", 8'hF0, 8'h10, 1'b1);
    // R6: nothing enabled
    sweep("R6 any none", 8'h00, 8'h00, 1'b0);
    sweep("R6 all none", 8'h00, 8'h00, 1'b1);
    sweep("R6 all none hi", 8'hFF, 8'h00, 1'b1);

    // R9: level mode ignores clear writes
    set_cfg(8'h01, 8'h01);
    wr('h00, 32'h4);
    pin_in = 8'h01; @(negedge clk); chk("R9 level set", 32'(irq), 32'd1);
    wr('h00, 32'h5); chk("R9 clear ignored", 32'(irq), 32'd1);
    rd('h00, d); chk("R10 ctrl status level", d, 32'h5);
    pin_in = 8'h00; @(negedge clk); chk("R9 level drop", 32'(irq), 32'd0);

    // R7 / R8: edge mode, any-combine
    wr('h00, 32'h1);
    @(negedge clk);
    chk("R8 initial clear", 32'(irq), 32'd0);
    pin_in = 8'h01; @(negedge clk); chk("R7 rise sets", 32'(irq), 32'd1);
    rd('h00, d); chk("R10 ctrl status edge", d, 32'h1);
    pin_in = 8'h00; @(negedge clk); chk("R7 sticky after fall", 32'(irq), 32'd1);
    wr('h00, 32'h0); chk("R8 zero write keeps", 32'(irq), 32'd1);
    wr('h00, 32'h1); chk("R8 clear", 32'(irq), 32'd0);
    rd('h00, d); chk("R10 ctrl cleared", d, 32'h0);
    // rise on the same edge as a clear
    @(negedge clk);
    pin_in = 8'h01; reg_wr = 1'b1; reg_addr = '0; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R8 rise beats clear", 32'(irq), 32'd1);
    wr('h00, 32'h1); chk("R8 clear with held condition", 32'(irq), 32'd0);
    repeat (3) @(negedge clk);
    chk("R7 held condition no retrigger", 32'(irq), 32'd0);

    // R7 with all-combine across two ports
    pin_in = 8'h00;
    set_cfg(8'h11, 8'h11);
    wr('h00, 32'h3);
    @(negedge clk); chk("R8 all clear", 32'(irq), 32'd0);
    pin_in = 8'h01; @(negedge clk); chk("R5 partial no rise", 32'(irq), 32'd0);
    pin_in = 8'h11; @(negedge clk); chk("R7 all cross-port rise", 32'(irq), 32'd1);
    pin_in = 8'h10; @(negedge clk); chk("R7 all sticky", 32'(irq), 32'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule